// File: doc/BRIEF.md
# Programmable 24-bit Down-Counter Timer

This block is a timer that sits on a byte-wide processor bus. Software places a 24-bit start value in three byte-sized preload registers. It then sets the enable bit in a control register. From that point the block decrements a 24-bit counter once per selected tick. A tick comes from one of three sources: the system clock itself, the system clock divided by 32, or rising edges on an external input pin.

When a decrement brings the count to zero, the block raises a sticky status flag. The control register then decides what the next tick does. Either the counter reloads from the preload value, which gives a periodic event every preload+1 ticks, or the counter wraps to all ones and keeps counting down.

A single output pin presents the zero event in one of two forms. In level mode it mirrors the status flag, so it can drive an interrupt request. In square-wave mode it toggles on each zero event. Software reads the live count as three read-only byte snapshots. It clears the flag by writing a one to it.

Top module: `dcount_timer`

## Requirements
- R1: After reset, the control, preload, counter and status registers all read 0x00, and `timerOut` is low.
- R2: The control register is read/write at offset 0x20. The preload bytes are read/write at 0x26 (bits 23:16), 0x28 (bits 15:8) and 0x2A (bits 7:0), and each byte is written alone. Offsets 0x24 and 0x2C read as 0x00, and writes to them change nothing.
- R3: Control bits [2:1] select the tick source. 00 gives one tick per clock. 01 gives one tick every 32 clocks, and the prescaler restarts from zero when the timer is enabled. 10 or 11 gives one tick per rising edge of `extTickIn`, taken after a two-stage synchroniser, and no tick while the input is static.
- R4: Control bit 0 is the enable. When it goes from 0 to 1, the first tick loads the counter from the preload value. While it is 0, no tick occurs and the counter holds its value.
- R5: Each tick that is not a load and finds the count non-zero decrements the count by one. A decrement that yields zero is a zero event.
- R6: With control bit 4 = 0, a tick at count zero reloads the preload value.
- R7: With control bit 4 = 1, a tick at count zero sets the count to 0xFFFFFF.
- R8: Status bit 0 at offset 0x34 is set by a zero event and stays set until a write with bit 0 = 1 to 0x34. A write with bit 0 = 0 has no effect. If a zero event and a clear fall in the same cycle, the set wins.
- R9: With control bit 5 = 0, `timerOut` equals status bit 0.
- R10: With control bit 5 = 1, `timerOut` toggles once on each zero event.
- R11: The counter is readable at 0x2E (bits 23:16), 0x30 (bits 15:8) and 0x32 (bits 7:0) as the live count. Writes to these offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 6 | Byte offset of the register accessed |
| busWr | input | 1 | Write strobe; the write takes effect on the next rising clock edge |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr`, combinational |
| extTickIn | input | 1 | Asynchronous external tick source |
| timerOut | output | 1 | Zero-event output: interrupt level or square wave |

## Verification
The in-RTL assertions check four things on every cycle. A zero event always sets the flag, and the flag never drops without a clear strobe. The count moves only on a tick, and each plain tick takes away exactly one. A rollover tick lands on all ones, and the square-wave state flips on every zero event. Divided ticks are never adjacent, and a rising enable always arms the pending load. The bench scenarios show what needs end-to-end timing and register decode: where the first load lands after enable, the exact divide-by-32 spacing, and the synchroniser delay on the external input. They also cover the register map and its dummy slots, the write-zero immunity of the status flag, and the output phase in each mode.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // Control register field positions
  localparam int EN_BIT   = 0;
  localparam int SRC_LSB  = 1;
  localparam int ROLL_BIT = 4;
  localparam int SQ_BIT   = 5;

  typedef enum logic [1:0] {
    SRC_CLK  = 2'b00,
    SRC_DIV  = 2'b01,
    SRC_EXTA = 2'b10,
    SRC_EXTB = 2'b11
  } tick_src_e;

  // Strobes and mode levels from control to datapath
  typedef struct packed {
    logic tick;
    logic loadReq;
    logic rollover;
    logic sqMode;
    logic zdsClr;
  } tmr_strobe_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int NUM_BYTES   = 3,
  parameter int PRESC_W     = 5,
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_OFS    = 'h20,
  parameter int PRE_OFS     = 'h26,
  parameter int CNT_OFS     = 'h2E,
  parameter int STAT_OFS    = 'h34,
  localparam int CNT_W      = 8 * NUM_BYTES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWr,
  input  logic [7:0]           busWrData,
  output logic [7:0]           busRdData,
  input  logic                 extTickIn,
  input  logic [CNT_W-1:0]     preloadVal,
  input  logic [CNT_W-1:0]     countVal,
  input  logic                 zdsFlag,
  output logic [NUM_BYTES-1:0] preWrEn,
  output tmr_strobe_t          strobes
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

  logic [7:0]             ctrlQ;
  logic                   pendQ;
  logic [PRESC_W-1:0]     prescQ;
  logic [SYNC_STAGES:0]   syncQ;
  logic [NUM_BYTES-1:0]   preHit, cntHit;
  logic                   ctrlWr, statWr, enOn, extRise, tick;
  tick_src_e              tickSrc;

  assign ctrlWr  = busWr && (busAddr == CTRL_A);
  assign statWr  = busWr && (busAddr == STAT_A);
  assign enOn    = ctrlQ[EN_BIT];
  assign tickSrc = tick_src_e'(ctrlQ[SRC_LSB +: 2]);
  assign extRise = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  always_comb begin
    unique case (tickSrc)
      SRC_CLK: tick = enOn;
      SRC_DIV: tick = enOn && (prescQ == '1);
      default: tick = enOn && extRise;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      pendQ  <= 1'b0;
      prescQ <= '0;
      syncQ  <= '0;
    end else begin
      if (ctrlWr) ctrlQ <= busWrData;
      if (ctrlWr && !busWrData[EN_BIT])             pendQ <= 1'b0;
      else if (ctrlWr && busWrData[EN_BIT] && !enOn) pendQ <= 1'b1;
      else if (tick)                                pendQ <= 1'b0;
      prescQ <= enOn ? prescQ + PRESC_W'(1) : '0;
      syncQ  <= {syncQ[SYNC_STAGES-1:0], extTickIn};
    end
  end

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_addr
    localparam logic [ADDR_W-1:0] PA = ADDR_W'(PRE_OFS + 2 * (NUM_BYTES - 1 - k));
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(CNT_OFS + 2 * (NUM_BYTES - 1 - k));
    assign preHit[k]  = (busAddr == PA);
    assign cntHit[k]  = (busAddr == CA);
    assign preWrEn[k] = busWr && preHit[k];
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == CTRL_A) busRdData = ctrlQ;
    if (busAddr == STAT_A) busRdData = {7'b0, zdsFlag};
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (preHit[k]) busRdData = preloadVal[k*8 +: 8];
      if (cntHit[k]) busRdData = countVal[k*8 +: 8];
    end
  end

  assign strobes.tick     = tick;
  assign strobes.loadReq  = pendQ;
  assign strobes.rollover = ctrlQ[ROLL_BIT];
  assign strobes.sqMode   = ctrlQ[SQ_BIT];
  assign strobes.zdsClr   = statWr && busWrData[0];

  // R3: divided ticks are never on adjacent cycles
  p_presc_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tickSrc == SRC_DIV && tick) |=> !tick);

  // R4: a rising enable always arms the first-tick load
  p_load_armed_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlQ[EN_BIT]) |-> pendQ);
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int NUM_BYTES = 3,
  localparam int CNT_W    = 8 * NUM_BYTES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tmr_strobe_t          strobes,
  input  logic [NUM_BYTES-1:0] preWrEn,
  input  logic [7:0]           wrByte,
  output logic [CNT_W-1:0]     preloadVal,
  output logic [CNT_W-1:0]     countVal,
  output logic                 zdsFlag,
  output logic                 timerOut
);
  logic [7:0]       preB [NUM_BYTES];
  logic [CNT_W-1:0] cntQ;
  logic             zdsQ, sqQ, zeroEvt;

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_pre
    always_ff @(posedge clk) begin
      if (!rstN)          preB[k] <= '0;
      else if (preWrEn[k]) preB[k] <= wrByte;
    end
    assign preloadVal[k*8 +: 8] = preB[k];
  end

  assign zeroEvt = strobes.tick && !strobes.loadReq && (cntQ == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      zdsQ <= 1'b0;
      sqQ  <= 1'b0;
    end else begin
      if (strobes.tick) begin
        if (strobes.loadReq)  cntQ <= preloadVal;
        else if (cntQ == '0)  cntQ <= strobes.rollover ? '1 : preloadVal;
        else                  cntQ <= cntQ - CNT_W'(1);
      end
      if (zeroEvt)             zdsQ <= 1'b1;
      else if (strobes.zdsClr) zdsQ <= 1'b0;
      if (zeroEvt) sqQ <= ~sqQ;
    end
  end

  assign countVal = cntQ;
  assign zdsFlag  = zdsQ;
  assign timerOut = strobes.sqMode ? sqQ : zdsQ;

  // R4: without a tick the count holds
  p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.tick |=> $stable(cntQ));

  // R5: an ordinary tick removes exactly one
  p_dec_one_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && !strobes.loadReq && cntQ > CNT_W'(1)) |=> cntQ == $past(cntQ) - CNT_W'(1));

  // R7: rollover lands on all ones
  p_roll_ones_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && !strobes.loadReq && cntQ == '0 && strobes.rollover) |=> (&cntQ));

  // R8: zero event sets the flag, and it never drops without a clear
  p_zds_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    zeroEvt |=> zdsQ);
  p_zds_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (zdsQ && !strobes.zdsClr) |=> zdsQ);

  // R10: square-wave state flips on every zero event
  p_sq_toggle_r10: assert property (@(posedge clk) disable iff (!rstN)
    zeroEvt |=> sqQ != $past(sqQ));
endmodule

// File: rtl/dcount_timer.sv
module dcount_timer
  import timer_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int NUM_BYTES   = 3,
  parameter int PRESC_W     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              extTickIn,
  output logic              timerOut
);
  localparam int CNT_W = 8 * NUM_BYTES;

  tmr_strobe_t          strobes;
  logic [NUM_BYTES-1:0] preWrEn;
  logic [CNT_W-1:0]     preloadVal, countVal;
  logic                 zdsFlag;

  timer_ctrl #(
    .ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES),
    .PRESC_W(PRESC_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .extTickIn(extTickIn),
    .preloadVal(preloadVal), .countVal(countVal), .zdsFlag(zdsFlag),
    .preWrEn(preWrEn), .strobes(strobes)
  );

  timer_datapath #(.NUM_BYTES(NUM_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .preWrEn(preWrEn),
    .wrByte(busWrData), .preloadVal(preloadVal), .countVal(countVal),
    .zdsFlag(zdsFlag), .timerOut(timerOut)
  );
endmodule

// File: tb/sim_dcount_timer.sv
module sim_dcount_timer;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       extTickIn = 1'b0;
  logic       timerOut;

  always #2.5 clk = ~clk;

  dcount_timer u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData),
    .extTickIn(extTickIn), .timerOut(timerOut)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  typedef struct packed {
    logic       wr;
    logic [5:0] a;
    logic [7:0] d;   // write data, or expected read value
    logic [3:0] req;
  } vec_t;

  // Register map vectors (R1 reset values, R2 map and dummy slots, R11 read-only counter)
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'h20, 8'h00, 4'd1},  // R1 control
    '{1'b0, 6'h26, 8'h00, 4'd1},  // R1 preload
    '{1'b0, 6'h2E, 8'h00, 4'd1},  // R1 counter
    '{1'b0, 6'h34, 8'h00, 4'd1},  // R1 status
    '{1'b1, 6'h26, 8'hAB, 4'd2},  // R2 preload high
    '{1'b1, 6'h28, 8'hCD, 4'd2},
    '{1'b1, 6'h2A, 8'hEF, 4'd2},
    '{1'b0, 6'h26, 8'hAB, 4'd2},
    '{1'b0, 6'h28, 8'hCD, 4'd2},
    '{1'b0, 6'h2A, 8'hEF, 4'd2},
    '{1'b0, 6'h24, 8'h00, 4'd2},  // R2 dummy slot
    '{1'b1, 6'h2C, 8'hFF, 4'd2},
    '{1'b0, 6'h2C, 8'h00, 4'd2},
    '{1'b1, 6'h30, 8'h55, 4'd11}, // R11 write ignored
    '{1'b0, 6'h30, 8'h00, 4'd11},
    '{1'b1, 6'h20, 8'h30, 4'd2},
    '{1'b0, 6'h20, 8'h30, 4'd2},
    '{1'b1, 6'h20, 8'h00, 4'd2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busAddr = '0;
  endtask

  // Combinational read; called only in the low clock phase
  task automatic busRead(input logic [5:0] a, output logic [7:0] d);
    busAddr = a;
    #0.3;
    d = busRdData;
  endtask

  task automatic readCount(output logic [23:0] v);
    logic [7:0] h, m, l;
    busRead(6'h2E, h);
    busRead(6'h30, m);
    busRead(6'h32, l);
    v = {h, m, l};
  endtask

  task automatic setPreload(input logic [23:0] p);
    busWrite(6'h26, p[23:16]);
    busWrite(6'h28, p[15:8]);
    busWrite(6'h2A, p[7:0]);
  endtask

  task automatic extPulse();
    @(negedge clk); extTickIn = 1'b1;
    waitNeg(4);
    extTickIn = 1'b0;
    waitNeg(4);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  rd;
    logic [23:0] cv, v0;
    logic        outRef;

    waitNeg(4);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 timerOut", timerOut, 0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) busWrite(VECS[i].a, VECS[i].d);
      else begin
        @(negedge clk);
        busRead(VECS[i].a, rd);
        check($sformatf("R%0d addr 0x%0h", VECS[i].req, VECS[i].a), rd, VECS[i].d);
      end
    end

    // Reload mode on the raw clock: R4, R5, R6, R8, R9
    setPreload(24'd5);
    busWrite(6'h20, 8'h01);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      readCount(cv);
      if (k == 1)      check("R4 first tick loads", cv, 5);
      else if (k <= 6) check("R5 decrement", cv, 6 - k);
      else             check("R6 reload", cv, (k == 7) ? 5 : 4);
      if (k == 5) begin busRead(6'h34, rd); check("R8 flag before zero", rd, 0); end
      if (k == 6) begin
        busRead(6'h34, rd); check("R8 flag at zero", rd, 1);
        check("R9 level output", timerOut, 1);
      end
    end
    busWrite(6'h20, 8'h00);
    readCount(v0);
    waitNeg(10);
    readCount(cv);
    check("R4 hold while disabled", cv, v0);
    busWrite(6'h34, 8'h00);
    @(negedge clk); busRead(6'h34, rd);
    check("R8 write zero ignored", rd, 1);
    busWrite(6'h34, 8'h01);
    @(negedge clk); busRead(6'h34, rd);
    check("R8 write one clears", rd, 0);
    check("R9 output follows flag", timerOut, 0);

    // Rollover: R7
    setPreload(24'd2);
    busWrite(6'h20, 8'h11);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      readCount(cv);
      case (k)
        1: check("R7 load", cv, 2);
        2: check("R7 dec", cv, 1);
        3: check("R7 zero", cv, 0);
        4: check("R7 wrap", cv, 24'hFFFFFF);
        default: check("R7 after wrap", cv, 24'hFFFFFE);
      endcase
    end
    busWrite(6'h20, 8'h00);
    busWrite(6'h34, 8'h01);

    // Divided clock: R3
    setPreload(24'd3);
    busWrite(6'h20, 8'h03);
    waitNeg(32); readCount(cv); check("R3 div32 first tick", cv, 3);
    waitNeg(31); readCount(cv); check("R3 div32 no early tick", cv, 3);
    waitNeg(1);  readCount(cv); check("R3 div32 second tick", cv, 2);
    busWrite(6'h20, 8'h00);

    // External input: R3
    setPreload(24'd4);
    busWrite(6'h20, 8'h05);
    readCount(v0);
    waitNeg(10); readCount(cv); check("R3 ext static no tick", cv, v0);
    extPulse(); readCount(cv); check("R3 ext edge loads", cv, 4);
    extPulse(); readCount(cv); check("R3 ext edge decrements", cv, 3);
    extPulse(); readCount(cv); check("R3 ext edge again", cv, 2);
    busWrite(6'h20, 8'h00);

    // Square wave: R10
    busWrite(6'h34, 8'h01);
    setPreload(24'd2);
    busWrite(6'h20, 8'h21);
    outRef = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 1) outRef = timerOut;
      if (k == 2) check("R10 steady before zero", timerOut, outRef);
      if (k == 3) check("R10 toggle at zero", timerOut, !outRef);
      if (k == 5) check("R10 steady between", timerOut, !outRef);
      if (k == 6) check("R10 toggle back", timerOut, outRef);
    end
    busWrite(6'h20, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule